// File: doc/BRIEF.md
# Double-Buffered Real-Time Clock Register File

This block holds the eight user-visible timekeeping registers of a real-time clock: seconds, minutes, hours, weekday, day of month, month, year and century, all in BCD. Each register is a user copy kept apart from the running calendar counter. The counter sits outside this block. The user copy normally follows the counter on every one-second tick. Software can freeze the copy to read a consistent time. It can also hold the copy to write a new time, and then commit that time to the counter in one parallel load. The counter keeps running the whole time.

Four control bits live inside the time registers. They are stored apart from the BCD fields and merged back in when a register is read:
- Century register: a read-hold bit and a write-hold bit.
- Seconds register: an oscillator-stop bit.
- Weekday register: a frequency-test bit.

The weekday register also reports a battery-good flag, which comes from a digital input and cannot be written. The bus side is a simple register port: a 3-bit index, a write strobe, write data, and combinational read data. The counter side is a 64-bit parallel snapshot with a tick, a 64-bit parallel load with a one-cycle strobe, and an oscillator-run output.

Top module: `rtc_dbuf_regfile`

## Requirements
- R1: After reset every register reads 0x00, except the weekday register (index 3). Its bit 7 equals `batt_good`, so it reads 0x80 when the battery is good. `osc_run` is 1 and `load_stb` is 0.
- R2: Bits with no field or control meaning read as 0. This holds whether the value came from a register write or from the counter snapshot. The field masks are: index 0 seconds 0x7F, index 1 minutes 0x7F, index 2 hours 0x3F, index 3 weekday 0x07, index 4 day of month 0x3F, index 5 month 0x1F, index 6 year 0xFF, index 7 century 0x3F.
- R3: While both hold bits are 0, a cycle with `cnt_tick` high copies every byte of `cnt_time` into the user registers. Byte i sits at bits [8i+7:8i] and belongs to register index i. The new values are readable in the next cycle.
- R4: Century bit 6 is the read-hold bit. While it is 1, ticks leave all user fields unchanged, so reads return the time captured before the hold was set.
- R5: After the read-hold bit is cleared, the next tick refreshes all user fields together from `cnt_time`.
- R6: Century bit 7 is the write-hold bit. While it is 1, ticks are ignored, register writes are stored into the fields, and `load_stb` stays 0.
- R7: A century write with bit 7 = 0 while the write-hold bit is 1 raises `load_stb` for exactly one cycle, starting at the clock edge of that write. During that cycle `load_time` carries all eight user fields in the R3 byte layout, including the century field from the clearing write, with all control bits at 0.
- R8: Seconds bit 7 is the oscillator-stop bit. It reads back as written, and `osc_run` is its inverse.
- R9: Weekday bit 6 is the frequency-test bit and reads back as written. While it is 1 and the oscillator runs, seconds bit 0 reads `ft_wave`. When the oscillator is stopped, seconds bit 0 reads the stored field bit.
- R10: Weekday bit 7 always reads `batt_good`. Writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_idx | input | 3 | Register index (0 seconds ... 7 century) |
| reg_wr | input | 1 | Write strobe for the indexed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the indexed register, fields merged with control bits |
| cnt_time | input | 64 | Counter snapshot, byte i = register i |
| cnt_tick | input | 1 | One-second update pulse from the counter |
| ft_wave | input | 1 | 512 Hz square wave for frequency test |
| batt_good | input | 1 | Battery status, 1 = good |
| load_stb | output | 1 | One-cycle strobe to load `load_time` into the counter |
| load_time | output | 64 | User fields in snapshot layout |
| osc_run | output | 1 | 1 while the oscillator is enabled |

## Verification
A hold bit that is stored wrong shows up at the ports on the next tick. Either the read data moves while it should stay frozen, or it stays stale after a tick that should refresh it. A lost or extra commit shows up on `load_stb` in the cycle right after the century write that clears the write-hold bit. Masking or merge errors show up on the very read that follows the write or tick, because the read path is combinational.

// File: rtl/rtc_rf_pkg.sv
package rtc_rf_pkg;
  localparam int IDX_W   = 3;
  localparam int BYTE_W  = 8;
  localparam int NUM_REG = 1 << IDX_W;

  localparam logic [IDX_W-1:0] IX_SEC  = 3'd0;
  localparam logic [IDX_W-1:0] IX_MIN  = 3'd1;
  localparam logic [IDX_W-1:0] IX_HOUR = 3'd2;
  localparam logic [IDX_W-1:0] IX_WDAY = 3'd3;
  localparam logic [IDX_W-1:0] IX_MDAY = 3'd4;
  localparam logic [IDX_W-1:0] IX_MON  = 3'd5;
  localparam logic [IDX_W-1:0] IX_YEAR = 3'd6;
  localparam logic [IDX_W-1:0] IX_CENT = 3'd7;

  // BCD field bits kept in the user copy of each register.
  function automatic logic [BYTE_W-1:0] field_mask(input logic [IDX_W-1:0] ix);
    case (ix)
      IX_SEC:  field_mask = 8'h7F;
      IX_MIN:  field_mask = 8'h7F;
      IX_HOUR: field_mask = 8'h3F;
      IX_WDAY: field_mask = 8'h07;
      IX_MDAY: field_mask = 8'h3F;
      IX_MON:  field_mask = 8'h1F;
      IX_YEAR: field_mask = 8'hFF;
      default: field_mask = 8'h3F;
    endcase
  endfunction
endpackage

// File: rtl/rtc_shadow_bank.sv
module rtc_shadow_bank
  import rtc_rf_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int DW = BYTE_W,
  localparam int NR = 1 << IW,
  localparam int TW = NR * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  input  logic [TW-1:0] cnt_flat,
  output logic [TW-1:0] shad_flat
);
  for (genvar g = 0; g < NR; g++) begin : g_reg
    localparam logic [IW-1:0] MY_IX = IW'(g);
    logic [DW-1:0] fld_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        fld_q <= '0;
      end else if (wr_en && wr_idx == MY_IX) begin
        fld_q <= wr_data & field_mask(MY_IX);
      end else if (take) begin
        fld_q <= cnt_flat[g*DW +: DW] & field_mask(MY_IX);
      end
    end
    assign shad_flat[g*DW +: DW] = fld_q;
  end
endmodule

// File: rtl/rtc_ctrl_bits.sv
module rtc_ctrl_bits
  import rtc_rf_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  output logic          rd_hold,
  output logic          wr_hold,
  output logic          osc_halt,
  output logic          ft_en,
  output logic          load_stb
);
  logic cent_wr, sec_wr, wday_wr;
  assign cent_wr = wr_en && (wr_idx == IX_CENT);
  assign sec_wr  = wr_en && (wr_idx == IX_SEC);
  assign wday_wr = wr_en && (wr_idx == IX_WDAY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_hold  <= 1'b0;
      wr_hold  <= 1'b0;
      osc_halt <= 1'b0;
      ft_en    <= 1'b0;
      load_stb <= 1'b0;
    end else begin
      load_stb <= cent_wr && wr_hold && !wr_data[7];
      if (cent_wr) begin
        rd_hold <= wr_data[6];
        wr_hold <= wr_data[7];
      end
      if (sec_wr)  osc_halt <= wr_data[7];
      if (wday_wr) ft_en    <= wr_data[6];
    end
  end
endmodule

// File: rtl/rtc_read_mux.sv
module rtc_read_mux
  import rtc_rf_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int DW = BYTE_W,
  localparam int NR = 1 << IW,
  localparam int TW = NR * DW
) (
  input  logic [IW-1:0] idx,
  input  logic [TW-1:0] shad_flat,
  input  logic          rd_hold,
  input  logic          wr_hold,
  input  logic          osc_halt,
  input  logic          ft_en,
  input  logic          ft_wave,
  input  logic          batt_good,
  output logic [DW-1:0] rdata
);
  always_comb begin
    rdata = shad_flat[int'(idx)*DW +: DW];
    case (idx)
      IX_SEC: begin
        rdata[DW-1] = osc_halt;
        if (ft_en && !osc_halt) rdata[0] = ft_wave;
      end
      IX_WDAY: begin
        rdata[DW-1] = batt_good;
        rdata[DW-2] = ft_en;
      end
      IX_CENT: begin
        rdata[DW-1] = wr_hold;
        rdata[DW-2] = rd_hold;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rtc_dbuf_regfile.sv
module rtc_dbuf_regfile
  import rtc_rf_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int DW = BYTE_W,
  localparam int NR = 1 << IW,
  localparam int TW = NR * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] reg_idx,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [TW-1:0] cnt_time,
  input  logic          cnt_tick,
  input  logic          ft_wave,
  input  logic          batt_good,
  output logic          load_stb,
  output logic [TW-1:0] load_time,
  output logic          osc_run
);
  logic          rd_hold, wr_hold, osc_halt, ft_en;
  logic          view_frozen;
  logic          upd_evt;
  logic [TW-1:0] shad_flat;

  // Follow the counter only while no hold bit is set and no commit is in flight.
  assign view_frozen = rd_hold | wr_hold;
  assign upd_evt     = cnt_tick & ~view_frozen & ~load_stb;

  rtc_ctrl_bits #(.IW(IW), .DW(DW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_idx(reg_idx), .wr_data(reg_wdata),
    .rd_hold(rd_hold), .wr_hold(wr_hold), .osc_halt(osc_halt), .ft_en(ft_en),
    .load_stb(load_stb)
  );

  rtc_shadow_bank #(.IW(IW), .DW(DW)) bank_i (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_idx(reg_idx), .wr_data(reg_wdata),
    .take(upd_evt), .cnt_flat(cnt_time), .shad_flat(shad_flat)
  );

  rtc_read_mux #(.IW(IW), .DW(DW)) rmux_i (
    .idx(reg_idx), .shad_flat(shad_flat), .rd_hold(rd_hold), .wr_hold(wr_hold),
    .osc_halt(osc_halt), .ft_en(ft_en), .ft_wave(ft_wave), .batt_good(batt_good),
    .rdata(reg_rdata)
  );

  assign load_time = shad_flat;
  assign osc_run   = ~osc_halt;
endmodule

// File: rtl/rtc_dbuf_regfile_chk.sv
module rtc_dbuf_regfile_chk
  import rtc_rf_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int DW = BYTE_W,
  localparam int TW = (1 << IW) * DW
) (
  input logic          clk,
  input logic          rst_n,
  input logic [IW-1:0] reg_idx,
  input logic          reg_wr,
  input logic [DW-1:0] reg_rdata,
  input logic          batt_good,
  input logic          load_stb,
  input logic          osc_run,
  input logic          rd_hold,
  input logic          wr_hold,
  input logic [TW-1:0] shad_flat
);
  a_r2_month_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx == IX_MON) |-> (reg_rdata[7:5] == 3'b000));

  a_r4_read_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hold && $past(rd_hold) && !$past(reg_wr)) |-> $stable(shad_flat));

  a_r6_write_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hold && $past(wr_hold) && !$past(reg_wr)) |-> $stable(shad_flat));

  a_r6_no_load_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hold |-> !load_stb);

  a_r7_load_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb);

  a_r7_load_on_hold_clear: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> ($past(wr_hold) && !wr_hold));

  a_r8_osc_bit_matches_run: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx == IX_SEC) |-> (reg_rdata[7] == !osc_run));

  a_r10_batt_flag_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx == IX_WDAY) |-> (reg_rdata[7] == batt_good));
endmodule

bind rtc_dbuf_regfile rtc_dbuf_regfile_chk #(.IW(IW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
  .batt_good(batt_good), .load_stb(load_stb), .osc_run(osc_run),
  .rd_hold(rd_hold), .wr_hold(wr_hold), .shad_flat(shad_flat)
);

// File: tb/rtc_dbuf_regfile_tb.sv
module rtc_dbuf_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_idx = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [63:0] cnt_time = '0;
  logic        cnt_tick = 1'b0;
  logic        ft_wave = 1'b0;
  logic        batt_good = 1'b1;
  logic        load_stb;
  logic [63:0] load_time;
  logic        osc_run;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  rtc_dbuf_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cnt_time(cnt_time), .cnt_tick(cnt_tick), .ft_wave(ft_wave),
    .batt_good(batt_good), .load_stb(load_stb), .load_time(load_time), .osc_run(osc_run)
  );

  function automatic logic [63:0] mk_time(input logic [7:0] s, mi, h, wd, md, mo, y, c);
    return {c, y, mo, md, wd, h, mi, s};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] ix, input logic [7:0] d);
    @(negedge clk);
    reg_idx = ix; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk_reg(input string req, input logic [2:0] ix, input logic [7:0] exp);
    reg_idx = ix;
    #1;
    check(req, {56'd0, reg_rdata}, {56'd0, exp});
  endtask

  task automatic tick(input logic [63:0] t);
    @(negedge clk);
    cnt_time = t; cnt_tick = 1'b1;
    @(negedge clk);
    cnt_tick = 1'b0;
  endtask

  // Expected reads of a time image with ft off, hold bits clear, battery good.
  task automatic chk_image(input string req, input logic [63:0] t, input logic [7:0] cent_ctl);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] e;
      e = t[i*8 +: 8];
      if (i == 3) e = e | 8'h80;
      if (i == 7) e = e | cent_ctl;
      chk_reg(req, 3'(i), e);
    end
  endtask

  task automatic t_reset();
    chk_image("R1 reset", 64'd0, 8'h00);
    check("R1 osc_run", {63'd0, osc_run}, 64'd1);
    check("R1 load_stb", {63'd0, load_stb}, 64'd0);
  endtask

  task automatic t_track();
    logic [63:0] t1;
    t1 = mk_time(8'h45, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99, 8'h20);
    tick(t1);
    chk_image("R3 track", t1, 8'h00);
    check("R3 no load", {63'd0, load_stb}, 64'd0);
  endtask

  task automatic t_mask();
    wr_reg(3'd5, 8'hFF);
    chk_reg("R2 month write mask", 3'd5, 8'h1F);
    wr_reg(3'd2, 8'hFF);
    chk_reg("R2 hour write mask", 3'd2, 8'h3F);
    tick(mk_time(8'hD2, 8'hFF, 8'hC1, 8'hFF, 8'hFF, 8'hE9, 8'h07, 8'hFF));
    chk_reg("R2 snap sec", 3'd0, 8'h52);
    chk_reg("R2 snap wday", 3'd3, 8'h87);
    chk_reg("R2 snap mon", 3'd5, 8'h09);
    chk_reg("R2 snap cent", 3'd7, 8'h3F);
  endtask

  task automatic t_read_hold();
    logic [63:0] t1, t2, t3;
    t1 = mk_time(8'h10, 8'h20, 8'h11, 8'h02, 8'h15, 8'h06, 8'h23, 8'h20);
    t2 = mk_time(8'h11, 8'h20, 8'h11, 8'h02, 8'h15, 8'h06, 8'h23, 8'h20);
    t3 = mk_time(8'h12, 8'h21, 8'h12, 8'h03, 8'h16, 8'h07, 8'h24, 8'h21);
    tick(t1);
    wr_reg(3'd7, 8'h60);
    tick(t2);
    chk_image("R4 frozen", t1, 8'h40);
    wr_reg(3'd7, 8'h20);
    chk_image("R5 before tick", t1, 8'h00);
    tick(t3);
    chk_image("R5 refreshed", t3, 8'h00);
  endtask

  task automatic t_write_hold();
    logic [63:0] exp_ld;
    wr_reg(3'd7, 8'hA1);
    wr_reg(3'd0, 8'h30);
    wr_reg(3'd1, 8'h15);
    wr_reg(3'd2, 8'h08);
    wr_reg(3'd3, 8'h02);
    wr_reg(3'd4, 8'h14);
    wr_reg(3'd5, 8'h07);
    wr_reg(3'd6, 8'h24);
    check("R6 no load in hold", {63'd0, load_stb}, 64'd0);
    tick(mk_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 8'h39));
    exp_ld = mk_time(8'h30, 8'h15, 8'h08, 8'h02, 8'h14, 8'h07, 8'h24, 8'h21);
    chk_image("R6 tick ignored", exp_ld, 8'h80);
    check("R6 no load after tick", {63'd0, load_stb}, 64'd0);
    wr_reg(3'd7, 8'h22);
    exp_ld[63:56] = 8'h22;
    check("R7 load strobe", {63'd0, load_stb}, 64'd1);
    check("R7 load value", load_time, exp_ld);
    @(negedge clk);
    check("R7 strobe one cycle", {63'd0, load_stb}, 64'd0);
  endtask

  task automatic t_osc();
    wr_reg(3'd0, 8'h80);
    check("R8 osc stopped", {63'd0, osc_run}, 64'd0);
    chk_reg("R8 stop bit read", 3'd0, 8'h80);
    wr_reg(3'd0, 8'h10);
    check("R8 osc running", {63'd0, osc_run}, 64'd1);
    chk_reg("R8 stop bit clear", 3'd0, 8'h10);
  endtask

  task automatic t_ft();
    wr_reg(3'd3, 8'h43);
    chk_reg("R9 ft bit read", 3'd3, 8'hC3);
    ft_wave = 1'b1;
    chk_reg("R9 wave high", 3'd0, 8'h11);
    ft_wave = 1'b0;
    chk_reg("R9 wave low", 3'd0, 8'h10);
    wr_reg(3'd0, 8'h90);
    ft_wave = 1'b1;
    chk_reg("R9 osc stopped", 3'd0, 8'h90);
    ft_wave = 1'b0;
    wr_reg(3'd0, 8'h10);
  endtask

  task automatic t_batt();
    batt_good = 1'b0;
    chk_reg("R10 batt low", 3'd3, 8'h43);
    wr_reg(3'd3, 8'hC3);
    chk_reg("R10 write ignored", 3'd3, 8'h43);
    batt_good = 1'b1;
    chk_reg("R10 batt good", 3'd3, 8'hC3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_track();
    t_mask();
    t_read_hold();
    t_write_hold();
    t_osc();
    t_ft();
    t_batt();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule